// File: doc/BRIEF.md
# Asynchronous External-Bus Slave Bridge

This block sits on the FPGA side of a 16-bit asynchronous memory bus that a host processor drives. The bus has no clock. Its strobes are all active low and idle high: two chip selects, a write enable, an output enable and two byte-lane enables. The bridge samples them into the local clock domain through a two-flop synchronizer. It uses whichever chip select is low to route each access to one of two targets. The control select reaches a small bank of word registers that can be read back. The data select reaches the push side of an external write stream and the pop side of an external read stream.

The address bus carries word addresses only. The data bus is split into an input, an output and an output-enable, so the pad ring can build the bidirectional pin. Read data is driven without a clock: the output-enable follows the raw strobes, so the host sees valid data while its own strobes are low. Writes are committed on the synchronized rising edge of write enable. A read on the data select finishes when the first of its chip select or output enable goes high, whichever order the two rise in. At that point the bridge issues exactly one pop.

Top module: `ebus_slave_bridge`

## Requirements
- R1: After reset `wr_push` and `rd_pop` are 0, `bus_d_oe` is 0 while the strobes idle high, and every control register reads back 0.
- R2: `bus_d_oe` is 1 only while one chip select and `bus_oe_n` are both low. It drops as soon as either of them rises, and it stays 0 for the whole of a write.
- R3: A write on the control select stores the data at the register whose index is the low `REG_AW` bits of `bus_a`. Each byte lane is written only if its enable is low: `bus_be_n[0]` guards bits 7:0 and `bus_be_n[1]` guards bits 15:8. A later control read of that address returns the stored word.
- R4: Each write on the data select with at least one byte enable low gives exactly one `wr_push` pulse, one clock wide. The pulse comes within six clocks after `bus_we_n` rises, and `wr_data` carries the bus word. Repeated writes give one push each.
- R5: A write with both byte enables high (`2'b11`) changes no register and gives no push.
- R6: During a read on the data select, `bus_d_out` shows `rd_data`. Each such read gives exactly one single-clock `rd_pop` pulse, whether the chip select rises before the output enable, together with it, or after it.
- R7: A read on the control select never pops, and a push never coincides with a pop.
- R8: A write-enable pulse while neither chip select is low has no effect on the registers or on the write stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low reset |
| bus_a | input | AW | Word address from the host |
| bus_d_in | input | DW | Data bus, host to bridge |
| bus_d_out | output | DW | Data bus, bridge to host |
| bus_d_oe | output | 1 | Drive enable for `bus_d_out` |
| bus_cs_ctl_n | input | 1 | Chip select for the register bank, active low |
| bus_cs_dat_n | input | 1 | Chip select for the stream port, active low |
| bus_we_n | input | 1 | Write enable, active low |
| bus_oe_n | input | 1 | Output enable, active low |
| bus_be_n | input | DW/8 | Byte-lane enables, active low |
| wr_data | output | DW | Word pushed into the write stream |
| wr_push | output | 1 | Push strobe for the write stream |
| rd_data | input | DW | Head word of the read stream |
| rd_pop | output | 1 | Pop strobe for the read stream |

## Verification
Register writes and readbacks are run from a vector table that covers:
- full-word writes;
- writes to the low lane only and to the high lane only, which separate the two lanes;
- a write with no lane enabled;
- the lowest and highest register indices, which show whether the address decode is complete.

Stream reads are run with the chip select rising first, with both strobes rising together, and with the output enable rising first. The read stream's head value steps on every pop, so a missing or doubled pop shows up in the data as well as in the pop count.

Orphan write-enable pulses, control reads and writes with no lane enabled check that a strobe pattern outside a valid access leaves the registers and both streams untouched.

// File: rtl/ebus_slave_bridge.sv
module ebus_slave_bridge #(
  parameter int DW     = 16,
  parameter int AW     = 10,
  parameter int REG_AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_a,
  input  logic [DW-1:0] bus_d_in,
  output logic [DW-1:0] bus_d_out,
  output logic          bus_d_oe,
  input  logic          bus_cs_ctl_n,
  input  logic          bus_cs_dat_n,
  input  logic          bus_we_n,
  input  logic          bus_oe_n,
  input  logic [DW/8-1:0] bus_be_n,
  output logic [DW-1:0] wr_data,
  output logic          wr_push,
  input  logic [DW-1:0] rd_data,
  output logic          rd_pop
);
  localparam int BW   = DW / 8;
  localparam int NREG = 1 << REG_AW;
  localparam int SW   = BW + 4;
  localparam int I_OE = BW;
  localparam int I_WE = BW + 1;
  localparam int I_CD = BW + 2;
  localparam int I_CC = BW + 3;
  localparam int PW   = AW + DW;

  logic [SW-1:0] st1, st2, st3;
  logic [PW-1:0] ad1, ad2, ad3;
  logic [DW-1:0] regs [NREG];
  logic          rd_open;

  // async read path: strobes gate the drive directly
  assign bus_d_oe  = (~bus_cs_ctl_n | ~bus_cs_dat_n) & ~bus_oe_n;
  assign bus_d_out = ~bus_cs_ctl_n ? regs[bus_a[REG_AW-1:0]] : rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st1 <= '1; st2 <= '1; st3 <= '1;
      ad1 <= '0; ad2 <= '0; ad3 <= '0;
    end else begin
      st1 <= {bus_cs_ctl_n, bus_cs_dat_n, bus_we_n, bus_oe_n, bus_be_n};
      st2 <= st1; st3 <= st2;
      ad1 <= {bus_a, bus_d_in};
      ad2 <= ad1; ad3 <= ad2;
    end
  end

  logic          we_rise, lane_any, ctl_wr, dat_wr, rd_act;
  logic [DW-1:0] wd;
  logic [REG_AW-1:0] widx;

  assign we_rise  = st2[I_WE] & ~st3[I_WE];
  assign lane_any = ~&st3[BW-1:0];
  assign ctl_wr   = we_rise & ~st3[I_CC];
  assign dat_wr   = we_rise & ~st3[I_CD] & lane_any;
  assign wd       = ad3[DW-1:0];
  assign widx     = ad3[DW +: REG_AW];
  assign rd_act   = ~st2[I_CD] & ~st2[I_OE];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (ctl_wr) begin
      for (int b = 0; b < BW; b++)
        if (!st3[b]) regs[widx][b*8 +: 8] <= wd[b*8 +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_push <= 1'b0;
      wr_data <= '0;
      rd_open <= 1'b0;
      rd_pop  <= 1'b0;
    end else begin
      wr_push <= dat_wr;
      if (dat_wr) wr_data <= wd;
      rd_pop  <= rd_open & ~rd_act;
      rd_open <= rd_act;
    end
  end

  assert_push_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_push |=> !wr_push);
  assert_pop_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pop |=> !rd_pop);
  assert_pop_follows_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pop |-> $past(rd_open));
  assert_push_not_pop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_push |-> !rd_pop);
endmodule

// File: tb/sim_ebus_slave_bridge.sv
`timescale 1ns/1ps
module sim_ebus_slave_bridge;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [9:0]  bus_a = '0;
  logic [15:0] bus_d_in = '0, bus_d_out, wr_data, rd_data;
  logic bus_d_oe, wr_push, rd_pop;
  logic cs_c = 1'b1, cs_d = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [1:0] be_n = 2'b11;
  int total = 0, bad = 0, push_cnt = 0, pop_cnt = 0;
  logic [15:0] last_push = '0;
  logic [15:0] model [64];
  bit done = 0;

  always #2.5 clk = ~clk;

  ebus_slave_bridge u0 (.clk(clk), .rst_n(rst_n), .bus_a(bus_a), .bus_d_in(bus_d_in),
    .bus_d_out(bus_d_out), .bus_d_oe(bus_d_oe), .bus_cs_ctl_n(cs_c), .bus_cs_dat_n(cs_d),
    .bus_we_n(we_n), .bus_oe_n(oe_n), .bus_be_n(be_n), .wr_data(wr_data),
    .wr_push(wr_push), .rd_data(rd_data), .rd_pop(rd_pop));

  assign rd_data = 16'hA500 + 16'(pop_cnt);

  always @(posedge clk) begin
    if (wr_push) begin push_cnt <= push_cnt + 1; last_push <= wr_data; end
    if (rd_pop) pop_cnt <= pop_cnt + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // sel: 0 data select, 1 control select, 2 none
  task automatic bus_write(input int sel, input logic [9:0] a, input logic [15:0] d,
                           input logic [1:0] be, output logic oe_mid);
    bus_a = a; bus_d_in = d; be_n = be;
    #5;  if (sel == 0) cs_d = 1'b0; else if (sel == 1) cs_c = 1'b0;
    #10; we_n = 1'b0;
    #20; oe_mid = bus_d_oe;
    #20; we_n = 1'b1; cs_c = 1'b1; cs_d = 1'b1;
    #40; be_n = 2'b11;
  endtask

  // order: 0 cs rises first, 1 together, 2 oe rises first
  task automatic bus_read(input int sel, input logic [9:0] a, input int order,
                          output logic [15:0] q, output logic drv, output logic rel);
    bus_a = a;
    #5;  if (sel == 0) cs_d = 1'b0; else cs_c = 1'b0;
    #10; oe_n = 1'b0;
    #40; q = bus_d_out; drv = bus_d_oe;
    if (order == 0) begin cs_c = 1'b1; cs_d = 1'b1; #1 rel = bus_d_oe; #14 oe_n = 1'b1; end
    else if (order == 1) begin cs_c = 1'b1; cs_d = 1'b1; oe_n = 1'b1; #1 rel = bus_d_oe; #14; end
    else begin oe_n = 1'b1; #1 rel = bus_d_oe; #14 cs_c = 1'b1; cs_d = 1'b1; end
    #40;
  endtask

  // {addr, data, be_n}
  localparam logic [27:0] VEC [6] = '{
    {10'd36, 16'hF00D, 2'b00}, {10'd36, 16'h12AB, 2'b10}, {10'd36, 16'h3456, 2'b01},
    {10'd0,  16'hBEEF, 2'b00}, {10'd63, 16'hCAFE, 2'b00}, {10'd63, 16'h1111, 2'b11}};

  initial begin
    logic [15:0] q; logic drv, rel, mid; int p0;
    for (int i = 0; i < 64; i++) model[i] = '0;
    #23 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 push idle", {31'd0, wr_push}, 0);
    chk("R1 pop idle", {31'd0, rd_pop}, 0);
    chk("R1 oe idle", {31'd0, bus_d_oe}, 0);
    bus_read(1, 10'd7, 1, q, drv, rel);
    chk("R1 reg reset", {16'd0, q}, 0);

    for (int i = 0; i < 6; i++) begin
      logic [9:0] a; logic [15:0] d; logic [1:0] be;
      {a, d, be} = VEC[i];
      bus_write(1, a, d, be, mid);
      chk("R2 no drive on write", {31'd0, mid}, 0);
      if (!be[0]) model[a[5:0]][7:0]  = d[7:0];
      if (!be[1]) model[a[5:0]][15:8] = d[15:8];
      bus_read(1, a, i % 3, q, drv, rel);
      chk(be == 2'b11 ? "R5 no lane" : "R3 readback", {16'd0, q}, {16'd0, model[a[5:0]]});
      chk("R2 drive during read", {31'd0, drv}, 1);
      chk("R2 release", {31'd0, rel}, 0);
    end
    chk("R7 ctl reads no pop", pop_cnt, 0);
    chk("R7 ctl writes no push", push_cnt, 0);

    bus_write(0, 10'd0, 16'h1234, 2'b00, mid);
    chk("R4 push 1", push_cnt, 1); chk("R4 data 1", {16'd0, last_push}, 32'h1234);
    bus_write(0, 10'd0, 16'h5678, 2'b00, mid);
    bus_write(0, 10'd0, 16'h9ABC, 2'b10, mid);
    chk("R4 push 3", push_cnt, 3); chk("R4 data 3", {16'd0, last_push}, 32'h9ABC);
    bus_write(0, 10'd0, 16'hDEAD, 2'b11, mid);
    chk("R5 no push", push_cnt, 3);

    bus_write(2, 10'd36, 16'h0BAD, 2'b00, mid);
    chk("R8 no push", push_cnt, 3);
    bus_read(1, 10'd36, 0, q, drv, rel);
    chk("R8 reg kept", {16'd0, q}, {16'd0, model[36]});

    for (int o = 0; o < 3; o++) begin
      p0 = pop_cnt;
      bus_read(0, 10'd0, o, q, drv, rel);
      chk("R6 stream data", {16'd0, q}, 32'hA500 + p0);
      chk("R6 one pop", pop_cnt, p0 + 1);
      chk("R2 release data read", {31'd0, rel}, 0);
    end
    chk("R7 no push on reads", push_cnt, 3);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule